// File: doc/BRIEF.md
# SPI Opcode Sequencer

This block is a half-duplex SPI master whose bus traffic is described by a short program rather than by individual commands. Software loads a 64-bit program word that holds up to eight one-byte opcodes. The opcodes pick a peripheral, send bytes from an 8-byte transmit holding register and collect bytes into an 8-byte receive holding register. Writing the program word starts execution at the top slot. The sequencer then runs on its own until it reaches a terminating opcode or has used all eight slots.

The transmit holding register and the receive holding register each have a full flag. A send opcode that finds the transmit register empty does not fail. It waits with the serial clock parked until software refills the register. The status word reports the sequencer state, the two full flags and sticky error flags. Those error flags record a transmit write that arrived while the register was full, a receive register that was overwritten before it was read, and a read of an empty receive register. A two-write pattern on the clock configuration word returns the whole block to its reset state.

Register words are 64 bits wide and are addressed by a 4-bit word offset: 3 clock configuration, 5 transmit data, 6 receive data, 7 program, 8 status. Every other offset reads as zero and ignores writes.

Top module: `spiseq_top`

## Requirements
- R1: After reset, cs_n is all ones, sck and mosi are 0, and status reads 64'h0001_0000_0000_0000. Status bit 48 means idle, bit 49 means running and bit 50 means waiting for transmit data. Status bit 63 is receive full, 62 receive overrun, 61 receive underrun, 59 transmit full and 58 transmit overrun. All other status bits read 0.
- R2: Writing offset 7 while idle starts the program. Opcodes run from bits 63:56 downward. Execution returns to idle at an opcode whose upper nibble is not 1, 3 or 4 (for example 0x00, 0xC0 or 0xE3), or after the eighth slot. A write to offset 7 while not idle is ignored, and offset 7 reads back the last accepted program.
- R3: Opcode 0x1n with n from 1 to 15 drives cs_n[n-1] low and every other line high. 0x10 drives all lines high. The select state is held after the program ends, including when it ends on a terminating opcode.
- R4: Opcode 0x3n sends n bytes of the transmit register, starting with bits 63:56, most significant bit first. An n above 8 counts as 8, and n = 0 does nothing. Taking the register for a send clears transmit full.
- R5: A send opcode that finds transmit full clear waits, with status bit 50 set and sck held low, until offset 5 is written.
- R6: Opcode 0x4n receives n bytes. The result is right-justified in the receive register, with the first byte in bits 8n-1:8n-8 and zeros above, and receive full is set. Reading offset 6 clears receive full.
- R7: The serial clock idles low (mode 0). Its period is 2×(D+1) system clocks, where D is clock configuration bits 63:52. MISO is sampled as sck rises, and mosi changes only as sck falls.
- R8: A write to offset 5 while transmit full is set raises transmit overrun and leaves the held data unchanged.
- R9: Completing a receive while receive full is still set raises receive overrun, and the new data replaces the old.
- R10: Reading offset 6 while receive full is clear raises receive underrun.
- R11: Writing zero to offset 8 clears the three overrun and underrun flags. A nonzero write to offset 8 has no effect.
- R12: A write to offset 3 with bits 39:36 = 4'b0101 arms a reset. A following write to offset 3 with bits 39:36 = 4'b1010 returns the sequencer, the flags and cs_n to their reset values. Neither of these two writes changes the stored clock configuration, and arming alone does not reset anything.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (drives read side effects) |
| reg_addr | input | 4 | Register word offset |
| reg_wdata | input | 64 | Register write data |
| reg_rdata | output | 64 | Register read data for reg_addr |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the peripheral |
| miso | input | 1 | Serial data from the peripheral |
| cs_n | output | NCS (15) | Active-low peripheral selects |

## Verification
The bench runs programs of four kinds. The first is a plain send. The second is a send followed by a receive, which shows that received bits land right-justified and only after the sent bits. The third is a pair of sends split across two refills, which shows the stall and confirms that the clock never pulses while the sequencer waits. The fourth is a full eight-slot select chain, which tells apart stopping on a terminating opcode from stopping after the last slot. A zero-length send placed before a one-byte send shows that the zero count is skipped rather than sent as eight bytes. Running the same byte pattern at two divider settings separates the clock period from the data ordering.

// File: rtl/spiseq_pkg.sv
package spiseq_pkg;

  typedef enum logic [1:0] {ST_IDLE, ST_FETCH, ST_TXWAIT, ST_SHIFT} seq_st_e;

  localparam logic [3:0] A_CLKCFG = 4'd3;
  localparam logic [3:0] A_TXD    = 4'd5;
  localparam logic [3:0] A_RXD    = 4'd6;
  localparam logic [3:0] A_SEQ    = 4'd7;
  localparam logic [3:0] A_STAT   = 4'd8;

  // byte count carried by a shift opcode, saturated at a full register
  function automatic logic [3:0] op_len(input logic [7:0] op);
    return (op[3:0] > 4'd8) ? 4'd8 : op[3:0];
  endfunction

  // one-hot sequencer state field placed at status bits 55:48
  function automatic logic [7:0] state_code(input seq_st_e s);
    case (s)
      ST_IDLE:   return 8'h01;
      ST_TXWAIT: return 8'h04;
      default:   return 8'h02;
    endcase
  endfunction

  function automatic logic is_rst_arm(input logic [63:0] v);
    return v[39:36] == 4'b0101;
  endfunction

  function automatic logic is_rst_fire(input logic [63:0] v);
    return v[39:36] == 4'b1010;
  endfunction

endpackage

// File: rtl/spiseq_shift_eng.sv
module spiseq_shift_eng #(
  parameter int W    = 64,
  parameter int DIVW = 12
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      clr,
  input  logic                      start,
  input  logic                      out_mode,
  input  logic [$clog2(W/8+1)-1:0]  nbytes,
  input  logic [W-1:0]              tx_word,
  input  logic [DIVW-1:0]           div,
  input  logic                      miso,
  output logic                      done,
  output logic [W-1:0]              sh_word,
  output logic                      sck,
  output logic                      mosi
);
  localparam int CW = $clog2(W + 1);

  logic [CW-1:0]   bits_left;
  logic [DIVW-1:0] hcnt;
  logic            busy, out_q, cap;

  wire half_end = busy && (hcnt == div);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; done <= 1'b0; sh_word <= '0; sck <= 1'b0; mosi <= 1'b0;
      bits_left <= '0; hcnt <= '0; out_q <= 1'b0; cap <= 1'b0;
    end else if (clr) begin
      busy <= 1'b0; done <= 1'b0; sh_word <= '0; sck <= 1'b0; mosi <= 1'b0;
      bits_left <= '0; hcnt <= '0; out_q <= 1'b0; cap <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        busy      <= 1'b1;
        out_q     <= out_mode;
        sh_word   <= out_mode ? tx_word : '0;
        mosi      <= out_mode & tx_word[W-1];
        bits_left <= CW'({nbytes, 3'b000});
        hcnt      <= '0;
        sck       <= 1'b0;
      end else if (half_end) begin
        hcnt <= '0;
        if (!sck) begin
          sck <= 1'b1;
          cap <= miso;
        end else begin
          sck       <= 1'b0;
          sh_word   <= {sh_word[W-2:0], cap};
          mosi      <= out_q & sh_word[W-2];
          bits_left <= bits_left - 1'b1;
          if (bits_left == CW'(1)) begin
            busy <= 1'b0;
            done <= 1'b1;
            mosi <= 1'b0;
          end
        end
      end else if (busy) begin
        hcnt <= hcnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/spiseq_ctrl.sv
module spiseq_ctrl
  import spiseq_pkg::*;
#(
  parameter int NCS = 15,
  parameter int W   = 64
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      clr,
  input  logic                      go,
  input  logic [W-1:0]              prog_in,
  input  logic                      tdr_full,
  input  logic                      eng_done,
  output logic                      eng_start,
  output logic                      eng_out,
  output logic [$clog2(W/8+1)-1:0]  eng_nbytes,
  output logic                      tx_consume,
  output logic                      rx_load,
  output logic [NCS-1:0]            cs_n,
  output seq_st_e                   st
);
  localparam int SLOTS = W / 8;
  localparam int SW    = $clog2(SLOTS + 1);

  logic [W-1:0]  prog;
  logic [SW-1:0] slot;
  logic          mode_out;

  wire [7:0] op     = prog[W-1 -: 8];
  wire [3:0] n      = op_len(op);
  wire       at_end = (slot == SW'(SLOTS));
  wire       in_f   = (st == ST_FETCH) && !at_end;
  wire       is_sel = in_f && (op[7:4] == 4'h1);
  wire       is_tx  = in_f && (op[7:4] == 4'h3);
  wire       is_rx  = in_f && (op[7:4] == 4'h4);
  wire       adv    = is_sel || ((is_tx || is_rx) && n == 4'd0) ||
                      (st == ST_SHIFT && eng_done);

  assign tx_consume = (st == ST_TXWAIT) && tdr_full;
  assign eng_start  = tx_consume || (is_rx && n != 4'd0);
  assign eng_out    = (st == ST_TXWAIT);
  assign eng_nbytes = ($clog2(W/8+1))'(n);
  assign rx_load    = (st == ST_SHIFT) && eng_done && !mode_out;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; prog <= '0; slot <= '0; mode_out <= 1'b0;
    end else if (clr) begin
      st <= ST_IDLE; prog <= '0; slot <= '0; mode_out <= 1'b0;
    end else begin
      if (adv) begin
        prog <= prog << 8;
        slot <= slot + 1'b1;
      end
      case (st)
        ST_IDLE:
          if (go) begin
            prog <= prog_in; slot <= '0; st <= ST_FETCH;
          end
        ST_FETCH:
          if (at_end || !(is_sel || is_tx || is_rx)) st <= ST_IDLE;
          else if (is_tx && n != 4'd0) st <= ST_TXWAIT;
          else if (is_rx && n != 4'd0) begin
            st <= ST_SHIFT; mode_out <= 1'b0;
          end
        ST_TXWAIT:
          if (tdr_full) begin
            st <= ST_SHIFT; mode_out <= 1'b1;
          end
        default:
          if (eng_done) st <= ST_FETCH;
      endcase
    end
  end

  for (genvar i = 0; i < NCS; i++) begin : g_cs
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cs_n[i] <= 1'b1;
      else if (clr)    cs_n[i] <= 1'b1;
      else if (is_sel) cs_n[i] <= (op[3:0] != 4'(i + 1));
    end
  end
endmodule

// File: rtl/spiseq_top.sv
module spiseq_top
  import spiseq_pkg::*;
#(
  parameter int NCS  = 15,
  parameter int W    = 64,
  parameter int DIVW = 12
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           reg_wr,
  input  logic           reg_rd,
  input  logic [3:0]     reg_addr,
  input  logic [W-1:0]   reg_wdata,
  output logic [W-1:0]   reg_rdata,
  output logic           sck,
  output logic           mosi,
  input  logic           miso,
  output logic [NCS-1:0] cs_n
);
  localparam int NBW = $clog2(W/8 + 1);

  logic [W-1:0] clkcfg, tdr, rdr, seq_reg, eng_word;
  logic         tdr_full, rdr_full, ovr_tx, ovr_rx, und_rx, rst_armed;
  logic         eng_start, eng_out, eng_done;
  logic [NBW-1:0] eng_nbytes;
  seq_st_e      st;

  // named events for the checker
  logic ev_tx_consume, ev_rx_load;
  wire  wr_cfg   = reg_wr && reg_addr == A_CLKCFG;
  wire  wr_txd   = reg_wr && reg_addr == A_TXD;
  wire  wr_stat  = reg_wr && reg_addr == A_STAT;
  wire  rd_rxd   = reg_rd && reg_addr == A_RXD;
  wire  st_idle  = (st == ST_IDLE);
  wire  st_txwait = (st == ST_TXWAIT);
  wire  seq_go   = reg_wr && reg_addr == A_SEQ && st_idle;
  wire  soft_rst = wr_cfg && rst_armed && is_rst_fire(reg_wdata);
  wire  cfg_step = is_rst_arm(reg_wdata) || soft_rst;

  spiseq_ctrl #(.NCS(NCS), .W(W)) u_ctrl (
    .clk, .rst_n, .clr(soft_rst), .go(seq_go), .prog_in(reg_wdata),
    .tdr_full, .eng_done, .eng_start, .eng_out, .eng_nbytes,
    .tx_consume(ev_tx_consume), .rx_load(ev_rx_load), .cs_n, .st
  );

  spiseq_shift_eng #(.W(W), .DIVW(DIVW)) u_eng (
    .clk, .rst_n, .clr(soft_rst), .start(eng_start), .out_mode(eng_out),
    .nbytes(eng_nbytes), .tx_word(tdr), .div(clkcfg[W-1 -: DIVW]), .miso,
    .done(eng_done), .sh_word(eng_word), .sck, .mosi
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clkcfg <= '0; seq_reg <= '0; rst_armed <= 1'b0;
    end else begin
      if (wr_cfg) begin
        rst_armed <= is_rst_arm(reg_wdata) && !soft_rst;
        if (!cfg_step) clkcfg <= reg_wdata;
      end
      if (seq_go) seq_reg <= reg_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tdr <= '0; rdr <= '0; tdr_full <= 1'b0; rdr_full <= 1'b0;
      ovr_tx <= 1'b0; ovr_rx <= 1'b0; und_rx <= 1'b0;
    end else if (soft_rst) begin
      tdr <= '0; rdr <= '0; tdr_full <= 1'b0; rdr_full <= 1'b0;
      ovr_tx <= 1'b0; ovr_rx <= 1'b0; und_rx <= 1'b0;
    end else begin
      if (wr_stat && reg_wdata == '0) begin
        ovr_tx <= 1'b0; ovr_rx <= 1'b0; und_rx <= 1'b0;
      end
      if (wr_txd) begin
        if (tdr_full) ovr_tx <= 1'b1;
        else begin
          tdr <= reg_wdata; tdr_full <= 1'b1;
        end
      end
      if (ev_tx_consume) tdr_full <= 1'b0;
      if (rd_rxd) begin
        if (rdr_full) rdr_full <= 1'b0;
        else          und_rx   <= 1'b1;
      end
      if (ev_rx_load) begin
        rdr <= eng_word; rdr_full <= 1'b1;
        if (rdr_full && !rd_rxd) ovr_rx <= 1'b1;
      end
    end
  end

  always_comb begin
    case (reg_addr)
      A_CLKCFG: reg_rdata = clkcfg;
      A_TXD:    reg_rdata = tdr;
      A_RXD:    reg_rdata = rdr;
      A_SEQ:    reg_rdata = seq_reg;
      A_STAT:   reg_rdata = {rdr_full, ovr_rx, und_rx, 1'b0, tdr_full, ovr_tx,
                             2'b00, state_code(st), 48'd0};
      default:  reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/spiseq_chk.sv
module spiseq_chk #(
  parameter int NCS = 15
) (
  input logic           clk,
  input logic           rst_n,
  input logic [NCS-1:0] cs_n,
  input logic           sck,
  input logic           st_idle,
  input logic           st_txwait,
  input logic           wr_txd,
  input logic           tdr_full,
  input logic           ovr_tx,
  input logic           ev_tx_consume,
  input logic           ev_rx_load,
  input logic           rdr_full,
  input logic           rd_rxd,
  input logic           und_rx,
  input logic           soft_rst
);
  // R3
  cs_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~cs_n));
  // R7
  sck_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st_idle |-> !sck);
  // R5
  stall_sck_parked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st_txwait |-> !sck);
  // R4
  tx_taken_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_tx_consume |=> !tdr_full);
  // R8
  tx_overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_txd && tdr_full) |=> ovr_tx);
  // R6
  rx_full_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_rx_load && !soft_rst) |=> rdr_full);
  // R10
  rx_underrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_rxd && !rdr_full && !soft_rst) |=> und_rx);
endmodule

bind spiseq_top spiseq_chk #(.NCS(NCS)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .st_idle(st_idle),
  .st_txwait(st_txwait), .wr_txd(wr_txd), .tdr_full(tdr_full),
  .ovr_tx(ovr_tx), .ev_tx_consume(ev_tx_consume), .ev_rx_load(ev_rx_load),
  .rdr_full(rdr_full), .rd_rxd(rd_rxd), .und_rx(und_rx), .soft_rst(soft_rst)
);

// File: tb/tb_spiseq_top.sv
module tb_spiseq_top;
  localparam int NCS = 15;
  localparam logic [NCS-1:0] ALL_OFF = '1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [3:0] reg_addr = '0;
  logic [63:0] reg_wdata = '0, reg_rdata;
  logic sck, mosi, miso;
  logic [NCS-1:0] cs_n;

  always #2 clk = ~clk;

  spiseq_top dut (.clk, .rst_n, .reg_wr, .reg_rd, .reg_addr, .reg_wdata,
                  .reg_rdata, .sck, .mosi, .miso, .cs_n);

  int checks = 0, errors = 0;
  logic finished = 1'b0;

  // peripheral model and bus monitor, sampled between edges
  logic [63:0] slv = '0;
  assign miso = slv[63];
  logic [63:0] mosi_log;
  logic [NCS-1:0] cs_at_rise;
  int rises, gap1, cyc, last_rise;
  logic sck_d = 1'b0;

  always @(negedge clk) begin
    cyc = cyc + 1;
    if (sck && !sck_d) begin
      if (rises == 1) gap1 = cyc - last_rise;
      last_rise = cyc;
      rises = rises + 1;
      mosi_log = {mosi_log[62:0], mosi};
      cs_at_rise = cs_n;
    end
    if (!sck && sck_d) slv = slv << 1;
    sck_d = sck;
  end

  task automatic clear_log();
    rises = 0; mosi_log = '0; gap1 = 0;
  endtask

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [63:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [63:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic wait_bit(input int b);
    logic [63:0] s;
    for (int i = 0; i < 4000; i++) begin
      rd(4'd8, s);
      if (s[b]) break;
    end
  endtask

  function automatic logic [NCS-1:0] sel_mask(input int k);
    return (k == 0) ? ALL_OFF : ~(NCS'(1) << (k - 1));
  endfunction

  task automatic t_reset();
    logic [63:0] s;
    rd(4'd8, s);
    check("R1 status", s, 64'h0001_0000_0000_0000);
    check("R1 cs_n", 64'(cs_n), 64'(ALL_OFF));
    check("R1 sck/mosi", {62'd0, sck, mosi}, 64'd0);
  endtask

  task automatic t_send_basic();
    logic [63:0] s;
    wr(4'd3, 64'h0020_0000_0000_0000);          // divider 2
    wr(4'd5, 64'hA1B2_C3D4_E5F6_0718);
    clear_log();
    wr(4'd7, 64'h1133_1000_0000_0000);
    wait_bit(48);
    check("R4 bytes out msb first", 64'(rises), 64'd24);
    check("R4 data", mosi_log[23:0], 64'hA1B2C3);
    check("R7 period div2", 64'(gap1), 64'd6);
    check("R3 select during send", 64'(cs_at_rise), 64'(sel_mask(1)));
    check("R3 deselect", 64'(cs_n), 64'(ALL_OFF));
    rd(4'd8, s);
    check("R4 tx full cleared", s, 64'h0001_0000_0000_0000);
    wr(4'd3, 64'h0);                             // divider 0
  endtask

  task automatic t_send_recv();
    logic [63:0] s;
    wr(4'd5, 64'h5A00_0000_0000_0000);
    slv = 64'h00C3_5E91_0000_0000;
    clear_log();
    wr(4'd7, 64'h1231_4310_0000_0000);
    wait_bit(48);
    check("R7 period div0", 64'(gap1), 64'd2);
    check("R6 cs during recv", 64'(cs_at_rise), 64'(sel_mask(2)));
    check("R4 sent byte", mosi_log[31:24], 64'h5A);
    rd(4'd8, s);
    check("R6 rx full", s, 64'h8001_0000_0000_0000);
    rd(4'd6, s);
    check("R6 right-justified", s, 64'h0000_0000_00C3_5E91);
    rd(4'd8, s);
    check("R6 read clears full", s, 64'h0001_0000_0000_0000);
  endtask

  task automatic t_stall();
    logic [63:0] s;
    clear_log();
    wr(4'd7, 64'h1132_3110_0000_0000);
    repeat (20) @(negedge clk);
    rd(4'd8, s);
    check("R5 waiting state", s, 64'h0004_0000_0000_0000);
    check("R5 no clock while waiting", 64'(rises), 64'd0);
    wr(4'd7, 64'h1F00_0000_0000_0000);           // ignored while busy
    wr(4'd5, 64'hBEEF_0000_0000_0000);
    wait_bit(50);
    check("R5 second stall no extra bits", 64'(rises), 64'd16);
    wr(4'd5, 64'h7700_0000_0000_0000);
    wait_bit(48);
    check("R5 data across refills", mosi_log[23:0], 64'hBEEF77);
    rd(4'd7, s);
    check("R2 busy write ignored", s, 64'h1132_3110_0000_0000);
    check("R2 busy write no select", 64'(cs_n), 64'(ALL_OFF));
  endtask

  task automatic t_tx_overrun();
    logic [63:0] s;
    wr(4'd5, 64'h1100_0000_0000_0000);
    wr(4'd5, 64'h2200_0000_0000_0000);
    rd(4'd8, s);
    check("R8 overrun flag", s, 64'h0C01_0000_0000_0000);
    clear_log();
    wr(4'd7, 64'h1131_1000_0000_0000);
    wait_bit(48);
    check("R8 first data kept", mosi_log[7:0], 64'h11);
    wr(4'd8, 64'h1);
    rd(4'd8, s);
    check("R11 nonzero write no effect", s, 64'h0401_0000_0000_0000);
    wr(4'd8, 64'h0);
    rd(4'd8, s);
    check("R11 zero write clears", s, 64'h0001_0000_0000_0000);
  endtask

  task automatic t_rx_errors();
    logic [63:0] s;
    wr(4'd5, 64'h0);
    slv = 64'h00A7_0000_0000_0000;
    wr(4'd7, 64'h1131_4110_0000_0000);
    wait_bit(48);
    wr(4'd5, 64'h0);
    slv = 64'h005C_0000_0000_0000;
    wr(4'd7, 64'h1131_4110_0000_0000);
    wait_bit(48);
    rd(4'd8, s);
    check("R9 rx overrun", s, 64'hC001_0000_0000_0000);
    rd(4'd6, s);
    check("R9 newest data kept", s, 64'h5C);
    rd(4'd6, s);
    rd(4'd8, s);
    check("R10 rx underrun", s, 64'h6001_0000_0000_0000);
    wr(4'd8, 64'h0);
  endtask

  task automatic t_stops();
    logic [63:0] s;
    wr(4'd5, 64'h9900_0000_0000_0000);
    wr(4'd7, 64'h11E3_3100_0000_0000);
    wait_bit(48);
    check("R3 select held after stop", 64'(cs_n), 64'(sel_mask(1)));
    rd(4'd8, s);
    check("R2 branch stops before send", s, 64'h0801_0000_0000_0000);
    wr(4'd7, 64'h12C0_3100_0000_0000);
    wait_bit(48);
    rd(4'd8, s);
    check("R2 copy opcode stops", s, 64'h0801_0000_0000_0000);
    clear_log();
    wr(4'd7, 64'h1030_3100_0000_0000);
    wait_bit(48);
    check("R4 zero count skipped", 64'(rises), 64'd8);
    check("R4 drained byte", mosi_log[7:0], 64'h99);
    wr(4'd7, 64'h1112_1314_1516_1718);
    wait_bit(48);
    check("R2 eight slots then idle", 64'(cs_n), 64'(sel_mask(8)));
  endtask

  task automatic t_soft_reset();
    logic [63:0] s;
    wr(4'd3, 64'h0010_0000_0000_0000);
    wr(4'd7, 64'h1331_0000_0000_0000);
    wait_bit(50);
    check("R3 select 3", 64'(cs_n), 64'(sel_mask(3)));
    wr(4'd3, 64'h0010_0050_0000_0000);
    rd(4'd8, s);
    check("R12 arm alone keeps state", s, 64'h0004_0000_0000_0000);
    wr(4'd3, 64'h0010_00A0_0000_0000);
    rd(4'd8, s);
    check("R12 reset to idle", s, 64'h0001_0000_0000_0000);
    check("R12 selects released", 64'(cs_n), 64'(ALL_OFF));
    rd(4'd3, s);
    check("R12 config kept", s, 64'h0010_0000_0000_0000);
  endtask

  initial begin
    clear_log();
    cyc = 0; last_rise = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_send_basic();
    t_send_recv();
    t_stall();
    t_tx_overrun();
    t_rx_errors();
    t_stops();
    t_soft_reset();
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule